// File: doc/BRIEF.md
# On-Delay Timer with Nonretentive Reset

This block is a synchronous on-delay timer in the style of a programmable-controller timing instruction. A single condition input starts it. While the condition stays true, an internal prescaler turns the system clock into intervals of a selectable length, one short and one long. An accumulator counts whole intervals until it reaches a programmable preset. Three registered flags report the state. The active flag says the condition is true. The running flag says the count is still short of the preset. The expired flag says the preset has been reached.

The timer is nonretentive. When the condition input drops, the accumulator, the three flags and the prescaler all clear on the next clock. This happens whether or not the timer has expired. A later true period therefore always counts from zero, starting with a full interval. The interval lengths are parameters. At a 100 MHz system clock, the defaults give 1 ms and 1 s.

Top module: `ondelay_timer`

## Requirements
- R1: `active` is 1 in the cycle after a clock edge that sampled `cond` = 1, and 0 in the cycle after an edge that sampled `cond` = 0 or `rst` = 1.
- R2: `running` is 1 exactly when `active` is 1 and `count` is below the preset; `running` and `expired` are never 1 together.
- R3: While `cond` is held, `count` rises by one every FAST_DIV clocks when `base_sel` = 0 (short base) and every SLOW_DIV clocks when `base_sel` = 1 (long base). The first increment comes on the FAST_DIV-th (or SLOW_DIV-th) edge that samples `cond` = 1, so the first interval is a full one.
- R4: On the edge where `count` becomes equal to the preset, `expired` goes to 1 and `running` goes to 0. `count` then holds while `cond` stays 1.
- R5: An edge that samples `cond` = 0 clears `count`, `active`, `running` and `expired` to 0, both before and after expiry, and also on an edge where an interval would have completed.
- R6: A true period released at 4 counts against a preset of 10 never raises `expired`, and the next true period counts again from 0.
- R7: With a preset of 0, `expired` is 1 after the first edge that samples `cond` = 1, and `running` stays 0.
- R8: `count` never exceeds the preset sampled on the previous edge. If the preset is lowered below the count, the next edge clamps `count` to the new preset and sets `expired`.
- R9: A synchronous active-high `rst` clears `count`, all three flags and the prescaler. If `cond` stays 1 afterwards, counting resumes from 0 with a full first interval.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cond | input | 1 | Condition input; timing runs while it is 1 |
| base_sel | input | 1 | Interval select: 0 short (FAST_DIV clocks), 1 long (SLOW_DIV clocks) |
| preset | input | ACC_W | Target count, unsigned |
| count | output | ACC_W | Accumulated whole intervals |
| active | output | 1 | Condition was true at the last edge |
| running | output | 1 | Active and count below preset |
| expired | output | 1 | Count has reached the preset |

## Verification
Two functions can act on the same edge: the clearing caused by a falling condition, and the interval completion that would raise the count to the preset. The bench holds the condition for one clock less than the time to expiry, so the release edge is the one where that interval ends. It then expects all outputs at zero and no expired pulse. Reset arriving while the condition is held is the second collision. There the expected counts after reset restart from zero with a full interval.

// File: rtl/ondly_pkg.sv
package ondly_pkg;
    typedef enum logic {
        BASE_SHORT = 1'b0,
        BASE_LONG  = 1'b1
    } base_e;
endpackage

// File: rtl/ondly_prescale.sv
module ondly_prescale #(
    parameter int FAST_DIV = 100000,
    parameter int SLOW_DIV = 100000000
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic base_sel,
    output logic tick
);
    import ondly_pkg::*;

    localparam int MAX_DIV = (FAST_DIV > SLOW_DIV) ? FAST_DIV : SLOW_DIV;
    localparam int CNT_W   = (MAX_DIV > 1) ? $clog2(MAX_DIV) : 1;
    localparam logic [CNT_W-1:0] FAST_LIM = CNT_W'(FAST_DIV - 1);
    localparam logic [CNT_W-1:0] SLOW_LIM = CNT_W'(SLOW_DIV - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } pre_t;

    pre_t             st_d, st_q;
    logic [CNT_W-1:0] limit;
    logic             wrap;

    always_comb begin
        limit = (base_e'(base_sel) == BASE_LONG) ? SLOW_LIM : FAST_LIM;
        wrap  = (st_q.cnt >= limit);
        tick  = run && wrap;
        st_d  = st_q;
        if (!run || wrap) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R3: each completed interval restarts the divider
    assert_tick_restart_R3: assert property (@(posedge clk) disable iff (rst)
        tick |=> (st_q.cnt == '0));

    // R5: an idle condition keeps the divider parked at zero
    assert_idle_parked_R5: assert property (@(posedge clk) disable iff (rst)
        !run |=> (st_q.cnt == '0));
endmodule

// File: rtl/ondly_core.sv
module ondly_core #(
    parameter int ACC_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cond,
    input  logic             tick,
    input  logic [ACC_W-1:0] preset,
    output logic [ACC_W-1:0] count,
    output logic             active,
    output logic             running,
    output logic             expired
);
    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic             en;
        logic             tt;
        logic             dn;
    } core_t;

    core_t            st_d, st_q;
    logic [ACC_W-1:0] nxt;

    always_comb begin
        st_d = st_q;
        nxt  = st_q.acc + {{(ACC_W-1){1'b0}}, tick};
        if (!cond) begin
            st_d = '0;
        end else begin
            st_d.en = 1'b1;
            if (st_q.acc >= preset) begin
                st_d.acc = preset;
                st_d.dn  = 1'b1;
                st_d.tt  = 1'b0;
            end else begin
                st_d.acc = nxt;
                st_d.dn  = (nxt == preset);
                st_d.tt  = (nxt != preset);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count   = st_q.acc;
    assign active  = st_q.en;
    assign running = st_q.tt;
    assign expired = st_q.dn;

    // R1: the active flag follows the condition of the previous edge
    assert_active_follows_R1: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (st_q.en == $past(cond)));

    // R2: running implies active and excludes expired
    assert_running_excl_R2: assert property (@(posedge clk) disable iff (rst)
        st_q.tt |-> (st_q.en && !st_q.dn));

    // R3: the count moves by at most one per edge unless clamped at expiry
    assert_count_step_R3: assert property (@(posedge clk) disable iff (rst)
        (st_q.en && $past(st_q.en)) |->
            ((st_q.acc == $past(st_q.acc)) || (st_q.acc == $past(st_q.acc) + 1'b1) || st_q.dn));

    // R4: expiry keeps the active flag up and the running flag down
    assert_expired_state_R4: assert property (@(posedge clk) disable iff (rst)
        st_q.dn |-> (st_q.en && !st_q.tt));

    // R5: an inactive timer holds nothing
    assert_cleared_R5: assert property (@(posedge clk) disable iff (rst)
        !st_q.en |-> ((st_q.acc == '0) && !st_q.tt && !st_q.dn));

    // R8: the count never passes the preset seen at the previous edge
    assert_acc_clamp_R8: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (st_q.acc <= $past(preset)));
endmodule

// File: rtl/ondelay_timer.sv
module ondelay_timer #(
    parameter int ACC_W    = 16,
    parameter int FAST_DIV = 100000,
    parameter int SLOW_DIV = 100000000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cond,
    input  logic             base_sel,
    input  logic [ACC_W-1:0] preset,
    output logic [ACC_W-1:0] count,
    output logic             active,
    output logic             running,
    output logic             expired
);
    logic tick;

    ondly_prescale #(
        .FAST_DIV (FAST_DIV),
        .SLOW_DIV (SLOW_DIV)
    ) u_prescale (
        .clk      (clk),
        .rst      (rst),
        .run      (cond),
        .base_sel (base_sel),
        .tick     (tick)
    );

    ondly_core #(
        .ACC_W (ACC_W)
    ) u_core (
        .clk     (clk),
        .rst     (rst),
        .cond    (cond),
        .tick    (tick),
        .preset  (preset),
        .count   (count),
        .active  (active),
        .running (running),
        .expired (expired)
    );

    // R9: one edge after reset every output is back at zero
    assert_reset_clear_R9: assert property (@(posedge clk)
        $past(rst) |-> ((count == '0) && !active && !running && !expired));
endmodule

// File: tb/ondelay_timer_test.sv
module ondelay_timer_test;
    localparam int W    = 16;
    localparam int FAST = 3;
    localparam int SLOW = 5;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         cond = 1'b0;
    logic         base_sel = 1'b0;
    logic [W-1:0] preset = '0;
    logic [W-1:0] count;
    logic         active, running, expired;

    typedef struct {
        logic         en;
        logic         tt;
        logic         dn;
        logic [W-1:0] acc;
        string        tag;
    } exp_t;

    exp_t q[$];
    int   vectors = 0;
    int   misses  = 0;
    bit   done    = 1'b0;

    always #5 clk = ~clk;

    ondelay_timer #(.ACC_W(W), .FAST_DIV(FAST), .SLOW_DIV(SLOW)) uut (
        .clk(clk), .rst(rst), .cond(cond), .base_sel(base_sel), .preset(preset),
        .count(count), .active(active), .running(running), .expired(expired)
    );

    task automatic step(input logic r, input logic c, input int pre, input logic sel,
                        input logic en, input logic tt, input logic dn, input int acc,
                        input string tag);
        exp_t e;
        @(negedge clk);
        rst = r; cond = c; preset = W'(pre); base_sel = sel;
        e.en = en; e.tt = tt; e.dn = dn; e.acc = W'(acc); e.tag = tag;
        q.push_back(e);
    endtask

    task automatic run(input int pre, input logic sel, input int hold, input string tag);
        int div;
        div = sel ? SLOW : FAST;
        for (int k = 1; k <= hold; k++) begin
            int a;
            a = k / div;
            if (a > pre) a = pre;
            step(0, 1, pre, sel, 1'b1, (a < pre), (a >= pre), a, tag);
        end
        step(0, 0, pre, sel, 1'b0, 1'b0, 1'b0, 0, tag);
    endtask

    always @(posedge clk) begin
        #2;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            vectors++;
            if (active !== e.en || running !== e.tt || expired !== e.dn || count !== e.acc) begin
                misses++;
                $display("FAIL %s: got en=%b tt=%b dn=%b acc=%0d expected en=%b tt=%b dn=%b acc=%0d",
                         e.tag, active, running, expired, count, e.en, e.tt, e.dn, e.acc);
            end
        end
    end

    initial begin
        int cyc;
        cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000) begin
                misses++;
                $display("FAIL watchdog: got timeout expected completion");
                $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
                $finish;
            end
        end
    end

    initial begin
        // R9: reset state
        step(1, 0, 0, 0, 0, 0, 0, 0, "R9 reset");
        step(1, 0, 0, 0, 0, 0, 0, 0, "R9 reset");
        // R1 R2 R3 R4: short base, preset 3, held past expiry
        run(3, 1'b0, 12, "R1/R2/R3/R4 short");
        // R3 R4 R5: long base, preset 2, released after expiry
        run(2, 1'b1, 14, "R3/R4/R5 long");
        // R6: release at 4 of 10, then restart from zero
        run(10, 1'b0, 12, "R6 first");
        run(10, 1'b0, 6, "R6 second");
        // R7: preset zero
        run(0, 1'b0, 4, "R7 zero");
        // R5: release on the edge where the final interval would complete
        run(2, 1'b0, 5, "R5 collide");
        // R8: lower preset below count
        for (int k = 1; k <= 15; k++)
            step(0, 1, 10, 0, 1'b1, 1'b1, 1'b0, k / FAST, "R8 build");
        step(0, 1, 3, 0, 1'b1, 1'b0, 1'b1, 3, "R8 clamp");
        step(0, 1, 3, 0, 1'b1, 1'b0, 1'b1, 3, "R8 hold");
        step(0, 0, 3, 0, 1'b0, 1'b0, 1'b0, 0, "R8 release");
        // R9: reset while condition held, then full-interval restart
        for (int k = 1; k <= 7; k++)
            step(0, 1, 10, 0, 1'b1, 1'b1, 1'b0, k / FAST, "R9 pre");
        step(1, 1, 10, 0, 1'b0, 1'b0, 1'b0, 0, "R9 mid reset");
        for (int k = 1; k <= 4; k++)
            step(0, 1, 10, 0, 1'b1, 1'b1, 1'b0, k / FAST, "R9 resume");
        step(0, 0, 10, 0, 1'b0, 1'b0, 1'b0, 0, "R9 release");
        repeat (4) @(posedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule